// File: doc/BRIEF.md
# Fault Protection and Hiccup Sequencer

This block decides whether a switching power controller may switch. Comparators outside the block turn supply and temperature into digital flags. A per-cycle current-limit pulse, the oscillator cycle tick and a microsecond time base also come in. The block combines them into one switching-enable and a record of what last stopped switching.

Switching starts once the supply has crossed its turn-on level. Two faults are latched: sustained overload and persistent overvoltage. After either one, switching stays off until the supply has collapsed below its turn-off level and then recovered above turn-on. This gives a hiccup pattern that repeats while the fault remains.

Over-temperature does not latch. It pauses switching only while it lasts. If the supply drains to turn-off during the pause, the normal undervoltage restart follows.

Top module: `prot_hiccup_seq`

## Requirements
- R1: While `rst_n` is low, `sw_en` is 0 and `fault_cause` is 0. After reset, `sw_en` stays 0 until `supply_on` is seen.
- R2: In the idle state, a clock edge with `supply_on`=1 and `supply_low`=0 starts switching, and `sw_en` is 1 from that edge on. Current-limit activity before that edge has no effect.
- R3: An oscillator cycle counts as limited when `ilim_pulse` was high at any clock within it, up to and including its `cyc_tick` clock. At the edge that ends the OLP_CYCLES-th consecutive limited cycle (default 2048), switching stops and `fault_cause` becomes 2 (overload).
- R4: A cycle that ends without a current-limit pulse restarts the overload count from zero. The count is also held at zero whenever `sw_en` is 0.
- R5: After an overload or overvoltage trip, `sw_en` stays 0 while `supply_on` is high. It also stays 0 until `supply_low` has been seen.
- R6: Once `supply_low` has been seen after a trip, the next edge with `supply_on`=1 restarts switching and clears `fault_cause` to 0.
- R7: Overvoltage trips only after `ovp_raw` has stayed high across OVP_US consecutive `us_tick` pulses (default 20). Any low clock on `ovp_raw` restarts the count. At the trip edge switching stops and `fault_cause` becomes 3.
- R8: While `otp_hot` is 1, `sw_en` is 0 in the same cycle. At the next edge in the running state, `fault_cause` becomes 4. When `otp_hot` drops, switching resumes without a supply cycle and the cause stays 4.
- R9: A clock edge with `supply_low`=1 in the running state stops switching and sets `fault_cause` to 1. The restart then waits for `supply_on`.
- R10: When several stop events occur at the same edge, the recorded cause follows the priority overvoltage, then overload, then undervoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_on | input | 1 | Supply above the turn-on level |
| supply_low | input | 1 | Supply below the turn-off level |
| ovp_raw | input | 1 | Undebounced supply overvoltage flag |
| otp_hot | input | 1 | Over-temperature flag (hysteresis applied outside) |
| ilim_pulse | input | 1 | Cycle-by-cycle current-limit event |
| cyc_tick | input | 1 | One-clock pulse at the end of each oscillator cycle |
| us_tick | input | 1 | One-clock pulse every microsecond |
| sw_en | output | 1 | Switching permitted |
| fault_cause | output | 3 | Last stop reason: 0 none, 1 undervoltage, 2 overload, 3 overvoltage, 4 over-temperature |

## Verification
The overload counter is run three ways: with 2047 limited cycles and then a clean cycle, with the full 2048, and with activity while switching is halted. This separates a counter that clears on a miss from one that only saturates, and one that is gated by the enable from one that counts anyway. The overvoltage filter gets a 19-tick burst, a one-clock glitch, a long high level with no time base, and a full 20-tick level. These show that it measures continuous time and not edges or clocks. Supply sequences check that supply_on alone cannot release a latched fault, and they run over-temperature across a supply collapse to separate the pause from the hiccup path. A coincident overvoltage and overload trip fixes the cause priority.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_UV   = 3'd1,
    CAUSE_OLP  = 3'd2,
    CAUSE_OVP  = 3'd3,
    CAUSE_OTP  = 3'd4
  } fault_cause_e;

  typedef enum logic [1:0] {
    S_WAIT_ON  = 2'd0,
    S_RUN      = 2'd1,
    S_WAIT_LOW = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fps_overload_counter.sv
module fps_overload_counter #(
  parameter int unsigned OLP_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cyc_tick,
  input  logic ilim_pulse,
  output logic trip
);
  localparam int unsigned CW = $clog2(OLP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OLP_CYCLES - 1);
  localparam logic [CW-1:0] TOP  = CW'(OLP_CYCLES);

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          hit;

  assign hit = seen_q | ilim_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cyc_tick) begin
      seen_q <= 1'b0;
      cnt_q  <= hit ? cnt_q + 1'b1 : '0;
    end else if (ilim_pulse) begin
      seen_q <= 1'b1;
    end
  end

  assign trip = arm & cyc_tick & hit & (cnt_q == LAST);

  // R4: a clean cycle restarts the run
  a_r4_clean_cycle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && cyc_tick && !hit) |=> (cnt_q == '0));
  // R4: no counting while switching is off
  a_r4_idle_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt_q == '0));
  // R3: the count never runs past the trip point
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/fps_ovp_filter.sv
module fps_ovp_filter #(
  parameter int unsigned OVP_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ovp_raw,
  input  logic us_tick,
  output logic trip
);
  localparam int unsigned CW = $clog2(OVP_US + 1);
  localparam logic [CW-1:0] LAST = CW'(OVP_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm || !ovp_raw) begin
      cnt_q <= '0;
    end else if (us_tick && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip = arm & ovp_raw & us_tick & (cnt_q == LAST);

  // R7: any low sample restarts the persistence window
  a_r7_glitch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !ovp_raw |=> (cnt_q == '0));
  // R7: the window advances only on the time base
  a_r7_time_based: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && ovp_raw && !us_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/fps_restart_fsm.sv
module fps_restart_fsm
  import fps_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_on,
  input  logic         supply_low,
  input  logic         otp_hot,
  input  logic         olp_trip,
  input  logic         ovp_trip,
  output logic         run,
  output fault_cause_e cause
);
  seq_state_e   state_q, state_d;
  fault_cause_e cause_q, cause_d;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      S_WAIT_ON: begin
        if (supply_on && !supply_low) begin
          state_d = S_RUN;
          cause_d = CAUSE_NONE;
        end
      end
      S_RUN: begin
        if (ovp_trip) begin
          state_d = S_WAIT_LOW;
          cause_d = CAUSE_OVP;
        end else if (olp_trip) begin
          state_d = S_WAIT_LOW;
          cause_d = CAUSE_OLP;
        end else if (supply_low) begin
          state_d = S_WAIT_ON;
          cause_d = CAUSE_UV;
        end else if (otp_hot) begin
          cause_d = CAUSE_OTP;
        end
      end
      S_WAIT_LOW: begin
        if (supply_low) state_d = S_WAIT_ON;
      end
      default: state_d = S_WAIT_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_WAIT_ON;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  assign run   = (state_q == S_RUN);
  assign cause = cause_q;

  // R5: a latched fault ignores supply_on until supply_low appears
  a_r5_latch_waits_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_LOW && !supply_low) |=> (state_q == S_WAIT_LOW));
  // R6: entering the running state always starts with a clean cause
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_ON && supply_on && !supply_low) |=> (cause_q == CAUSE_NONE));
endmodule

// File: rtl/prot_hiccup_seq.sv
module prot_hiccup_seq
  import fps_pkg::*;
#(
  parameter int unsigned OLP_CYCLES = 2048,
  parameter int unsigned OVP_US     = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_on,
  input  logic       supply_low,
  input  logic       ovp_raw,
  input  logic       otp_hot,
  input  logic       ilim_pulse,
  input  logic       cyc_tick,
  input  logic       us_tick,
  output logic       sw_en,
  output logic [2:0] fault_cause
);
  logic         run;
  logic         olp_trip;
  logic         ovp_trip;
  fault_cause_e cause;

  fps_overload_counter #(.OLP_CYCLES(OLP_CYCLES)) u_olp (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (sw_en),
    .cyc_tick   (cyc_tick),
    .ilim_pulse (ilim_pulse),
    .trip       (olp_trip)
  );

  fps_ovp_filter #(.OVP_US(OVP_US)) u_ovp (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (run),
    .ovp_raw (ovp_raw),
    .us_tick (us_tick),
    .trip    (ovp_trip)
  );

  fps_restart_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_on  (supply_on),
    .supply_low (supply_low),
    .otp_hot    (otp_hot),
    .olp_trip   (olp_trip),
    .ovp_trip   (ovp_trip),
    .run        (run),
    .cause      (cause)
  );

  assign sw_en       = run & ~otp_hot;
  assign fault_cause = cause;

  // R8: heat blocks switching in the same cycle
  a_r8_hot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    otp_hot |-> !sw_en);
  // R9: a low supply never leaves switching on
  a_r9_low_stops: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !sw_en);
  // R3: an overload trip stops switching at once
  a_r3_olp_stops: assert property (@(posedge clk) disable iff (!rst_n)
    olp_trip |=> !sw_en);
  // R10: overvoltage wins every coincidence
  a_r10_ovp_first: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_trip |=> (fault_cause == 3'd3));
endmodule

// File: tb/prot_hiccup_seq_tb_top.sv
`timescale 1ns/1ps
module prot_hiccup_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_on = 1'b0, supply_low = 1'b0, ovp_raw = 1'b0, otp_hot = 1'b0;
  logic ilim_pulse = 1'b0, cyc_tick = 1'b0, us_tick = 1'b0;
  logic sw_en;
  logic [2:0] fault_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic       en;
    logic [2:0] cause;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  prot_hiccup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .supply_on(supply_on), .supply_low(supply_low),
    .ovp_raw(ovp_raw), .otp_hot(otp_hot), .ilim_pulse(ilim_pulse),
    .cyc_tick(cyc_tick), .us_tick(us_tick), .sw_en(sw_en), .fault_cause(fault_cause)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      checks++;
      if (sw_en !== x.en || fault_cause !== x.cause) begin
        failures++;
        $display("FAIL %s: sw_en=%0b cause=%0d expected sw_en=%0b cause=%0d",
                 x.tag, sw_en, fault_cause, x.en, x.cause);
      end
    end
  end

  task automatic step(input bit chk, input logic e, input logic [2:0] c, input string tag);
    @(posedge clk);
    #2;
    if (chk) exp_q.push_back('{e, c, tag});
    @(negedge clk);
    #1;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, "");
  endtask

  task automatic hiccup(input string tag);
    supply_on = 1'b0; supply_low = 1'b1; step(1'b0, 1'b0, 3'd0, "");
    supply_low = 1'b0; supply_on = 1'b1; step(1'b1, 1'b1, 3'd0, tag);
  endtask

  initial begin
    @(negedge clk); #1;
    step(1'b1, 1'b0, 3'd0, "R1 during reset");
    step(1'b1, 1'b0, 3'd0, "R1 during reset");
    rst_n = 1'b1;
    step(1'b1, 1'b0, 3'd0, "R1 idle without supply");
    ilim_pulse = 1'b1; cyc_tick = 1'b1;
    run_n(5);
    step(1'b1, 1'b0, 3'd0, "R2 limiting before turn-on ignored");
    ilim_pulse = 1'b0; cyc_tick = 1'b0; supply_on = 1'b1;
    step(1'b1, 1'b1, 3'd0, "R2 turn-on enables");

    // overload counting
    ilim_pulse = 1'b1; cyc_tick = 1'b1;
    run_n(2046);
    step(1'b1, 1'b1, 3'd0, "R3 2047 limited cycles still running");
    ilim_pulse = 1'b0;
    step(1'b1, 1'b1, 3'd0, "R4 clean cycle");
    ilim_pulse = 1'b1;
    run_n(2046);
    step(1'b1, 1'b1, 3'd0, "R4 count restarted after clean cycle");
    step(1'b1, 1'b0, 3'd2, "R3 overload trip");

    // latched hold and hiccup
    ilim_pulse = 1'b0; cyc_tick = 1'b0;
    run_n(10);
    step(1'b1, 1'b0, 3'd2, "R5 latched despite supply_on");
    supply_on = 1'b0; supply_low = 1'b1;
    step(1'b1, 1'b0, 3'd2, "R5 supply collapsing");
    supply_low = 1'b0;
    step(1'b1, 1'b0, 3'd2, "R5 supply between levels");
    supply_on = 1'b1;
    step(1'b1, 1'b1, 3'd0, "R6 restart clears cause");

    // overvoltage filter
    ovp_raw = 1'b1; us_tick = 1'b1;
    run_n(18);
    step(1'b1, 1'b1, 3'd0, "R7 19 us still running");
    ovp_raw = 1'b0;
    step(1'b1, 1'b1, 3'd0, "R7 glitch restarts window");
    ovp_raw = 1'b1; us_tick = 1'b0;
    run_n(49);
    step(1'b1, 1'b1, 3'd0, "R7 no time base no trip");
    us_tick = 1'b1;
    run_n(19);
    step(1'b1, 1'b0, 3'd3, "R7 overvoltage trip");
    ovp_raw = 1'b0; us_tick = 1'b0;
    step(1'b1, 1'b0, 3'd3, "R5 overvoltage latched");
    hiccup("R6 restart after overvoltage");

    // over-temperature pause
    otp_hot = 1'b1;
    step(1'b1, 1'b0, 3'd4, "R8 heat halts");
    ilim_pulse = 1'b1; cyc_tick = 1'b1;
    run_n(2100);
    step(1'b1, 1'b0, 3'd4, "R4 no count while halted");
    otp_hot = 1'b0; ilim_pulse = 1'b0; cyc_tick = 1'b0;
    step(1'b1, 1'b1, 3'd4, "R8 resumes and keeps cause");

    // undervoltage
    supply_on = 1'b0; supply_low = 1'b1;
    step(1'b1, 1'b0, 3'd1, "R9 undervoltage stop");
    supply_low = 1'b0;
    step(1'b1, 1'b0, 3'd1, "R9 waits for turn-on");
    supply_on = 1'b1;
    step(1'b1, 1'b1, 3'd0, "R6 restart after undervoltage");

    // heat across a supply collapse
    otp_hot = 1'b1;
    step(1'b1, 1'b0, 3'd4, "R8 heat halts again");
    supply_on = 1'b0; supply_low = 1'b1;
    step(1'b1, 1'b0, 3'd1, "R9 collapse while hot");
    supply_low = 1'b0; supply_on = 1'b1;
    step(1'b1, 1'b0, 3'd0, "R8 restart still hot");
    step(1'b1, 1'b0, 3'd4, "R8 hot recorded after restart");
    otp_hot = 1'b0;
    step(1'b1, 1'b1, 3'd4, "R8 release after hiccup");

    // coincident overload and overvoltage trips
    ilim_pulse = 1'b1; cyc_tick = 1'b1;
    for (int i = 0; i < 2048; i++) begin
      ovp_raw = (i >= 2028);
      us_tick = (i >= 2028);
      step(i == 2047, 1'b0, 3'd3, "R10 overvoltage outranks overload");
    end
    ilim_pulse = 1'b0; cyc_tick = 1'b0; ovp_raw = 1'b0; us_tick = 1'b0;
    hiccup("R6 restart after coincident trip");

    @(posedge clk); @(negedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule